// File: doc/BRIEF.md
# Two-Wire Write-Only Control Register Slave

This block is a serial slave on a two-wire bus. SCL and SDA are sampled on a fast system clock. It accepts write transactions of exactly three bytes: a device address, a register selector and a data byte. The data byte lands in one of nineteen 8-bit control registers. In most of these registers the low six bits set an analog trim level, and the upper bits act as enable and select flags. The slave acknowledges each accepted byte by pulling SDA low through an open-drain enable. It never reads back, never stretches the clock and never auto-increments.

Incoming data first goes to a staging copy. Staged values reach the register outputs only while the vertical-blank input is high, so settings change only during retrace. A write of zero to the command selector is a strobe. It emits a one-cycle pulse that restarts the horizontal loop, unless bit 6 of selector 0x88 is set.

Top module: `ctl_reg_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high. It begins a new transaction with a cleared bit count and byte count.
- R2: The first byte is acknowledged only when it equals 0x8A. An acknowledge means SDA is held low for the whole ninth clock after the byte.
- R3: The second byte selects the target register. Selector 0x77..0x88 maps to index k = selector - 0x77, and selector 0x00 maps to index 18. Register k appears on `regs_o[8k+7:8k]`. A valid selector is acknowledged.
- R4: When the first byte is not 0x8A, it is not acknowledged. Every later byte is then ignored and unacknowledged until the next start.
- R5: A selector outside the valid set is not acknowledged. The following data byte is neither stored nor acknowledged.
- R6: The third byte is stored into the staging copy of the selected register and is acknowledged. `regs_o` copies the staging values on each clock where `vblank_i` is high, and holds while it is low.
- R7: `hloop_start_o` pulses high for exactly one clock when data 0x00 is written to selector 0x00 while bit 6 of the output register for selector 0x88 is 0. Nonzero data, or bit 6 set, gives no pulse.
- R8: A stop condition is SDA rising while SCL is high. It returns the slave to idle, so bytes sent without a new start are not acknowledged. A stop before the third byte is complete changes no register.
- R9: During reset all staged and output registers are 0x00, and both `sda_oe_o` and `hloop_start_o` are low.
- R10: A start in the middle of a byte or of a transaction abandons the partial transaction. The next three bytes are decoded as a fresh write.
- R11: `sda_oe_o` is high only during acknowledge bits. It changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| vblank_i | input | 1 | High during vertical retrace; allows the staged copy to reach the outputs |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain acknowledge) |
| regs_o | output | 152 | Nineteen output registers, index k at bits 8k+7:8k |
| hloop_start_o | output | 1 | One-clock horizontal-loop start pulse |

## Verification
A byte counter that drifts, or a selector decoded wrongly, shows up within one byte period. The symptom is a missing or extra low level on SDA during the ninth clock, or a value landing at the wrong index of `regs_o` once blanking is high. If the staging and output copies were merged, a write made outside blanking would show at the outputs within two clocks. A wrong gate on the command strobe shows up as a miscounted pulse on `hloop_start_o` right after the third byte.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int unsigned NUM_REGS   = 19;
  localparam int unsigned DW         = 8;
  localparam int unsigned IDX_W      = $clog2(NUM_REGS);
  localparam logic [7:0]  DEV_ADDR   = 8'h8A;
  localparam logic [7:0]  SUB_LO     = 8'h77;
  localparam logic [7:0]  SUB_HI     = 8'h88;
  localparam logic [7:0]  SUB_CMD    = 8'h00;
  localparam int unsigned CMD_IDX    = NUM_REGS - 1;
  localparam int unsigned GATE_IDX   = int'(SUB_HI - SUB_LO);
  localparam int unsigned GATE_BIT   = 6;

  typedef enum logic [2:0] {
    RX_IDLE, RX_BITS, RX_ACK_WAIT, RX_ACK, RX_SKIP
  } rx_state_e;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] idx;
  } sub_map_t;

  function automatic sub_map_t map_sub(input logic [7:0] sub);
    sub_map_t m;
    m.ok  = 1'b0;
    m.idx = '0;
    if (sub == SUB_CMD) begin
      m.ok  = 1'b1;
      m.idx = IDX_W'(CMD_IDX);
    end else if (sub >= SUB_LO && sub <= SUB_HI) begin
      m.ok  = 1'b1;
      m.idx = IDX_W'(sub - SUB_LO);
    end
    return m;
  endfunction
endpackage

// File: rtl/ctl_bus_sync.sv
module ctl_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges only count while clock stays high across both samples
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx
  import ctl_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             ack_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [DW-1:0]    wr_data_o
);
  rx_state_e        state;
  logic [2:0]       bit_cnt;
  logic [1:0]       byte_cnt;
  logic [DW-2:0]    shreg;
  logic [IDX_W-1:0] sub_idx;
  logic [DW-1:0]    rx_byte;
  sub_map_t         sub_map;

  assign rx_byte = {shreg, sda_i};
  assign sub_map = map_sub(rx_byte);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= RX_IDLE;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      shreg     <= '0;
      sub_idx   <= '0;
      ack_o     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state    <= RX_BITS;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        ack_o    <= 1'b0;
      end else if (stop_i) begin
        state <= RX_IDLE;
        ack_o <= 1'b0;
      end else begin
        unique case (state)
          RX_BITS: if (scl_rise_i) begin
            shreg   <= rx_byte[DW-2:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              state <= RX_ACK_WAIT;
              unique case (byte_cnt)
                2'd0: if (rx_byte != DEV_ADDR) state <= RX_SKIP;
                2'd1: begin
                  if (sub_map.ok) sub_idx <= sub_map.idx;
                  else            state   <= RX_SKIP;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= sub_idx;
                  wr_data_o <= rx_byte;
                end
              endcase
            end
          end
          RX_ACK_WAIT: if (scl_fall_i) begin
            ack_o <= 1'b1;
            state <= RX_ACK;
          end
          RX_ACK: if (scl_fall_i) begin
            ack_o   <= 1'b0;
            bit_cnt <= '0;
            if (byte_cnt == 2'd2) state <= RX_SKIP;
            else begin
              byte_cnt <= byte_cnt + 2'd1;
              state    <= RX_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 vblank_i,
  output logic [NUM_REGS*DW-1:0] regs_o,
  output logic                 hloop_start_o
);
  logic [DW-1:0] staged [NUM_REGS];
  logic [DW-1:0] active [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        staged[k] <= '0;
        active[k] <= '0;
      end else begin
        if (wr_en_i && wr_idx_i == IDX_W'(k)) staged[k] <= wr_data_i;
        if (vblank_i) active[k] <= staged[k];
      end
    end
    assign regs_o[k*DW +: DW] = active[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hloop_start_o <= 1'b0;
    else hloop_start_o <= wr_en_i && wr_idx_i == IDX_W'(CMD_IDX) &&
                          wr_data_i == '0 && !active[GATE_IDX][GATE_BIT];
  end
endmodule

// File: rtl/ctl_reg_slave.sv
module ctl_reg_slave
  import ctl_reg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   vblank_i,
  output logic                   sda_oe_o,
  output logic [NUM_REGS*DW-1:0] regs_o,
  output logic                   hloop_start_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [DW-1:0] wr_data;

  ctl_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  ctl_serial_rx i_rx (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .ack_o(sda_oe_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  ctl_reg_bank i_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .vblank_i, .regs_o, .hloop_start_o
  );
endmodule

// File: rtl/ctl_reg_slave_chk.sv
module ctl_reg_slave_chk
  import ctl_reg_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   scl_i,
  input logic                   vblank_i,
  input logic                   sda_oe_o,
  input logic [NUM_REGS*DW-1:0] regs_o,
  input logic                   hloop_start_o
);
  localparam int unsigned GATE_POS = GATE_IDX*DW + GATE_BIT;

  always @(posedge clk_i)
    if (!rst_ni)
      AST_RESET_CLEAR: assert (regs_o == '0 && !sda_oe_o && !hloop_start_o) // R9
        else $error("outputs not clear in reset");

  AST_HOLD_OUTSIDE_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vblank_i) |-> $stable(regs_o)) else $error("regs moved outside blank"); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hloop_start_o |=> !hloop_start_o) else $error("pulse too long"); // R7

  AST_PULSE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hloop_start_o |-> !$past(regs_o[GATE_POS])) else $error("pulse while gated"); // R7

  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i) else $error("ack rose with SCL high"); // R11

  AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_i) else $error("ack fell with SCL high"); // R11
endmodule

bind ctl_reg_slave ctl_reg_slave_chk i_chk (.*);

// File: tb/test_ctl_reg_slave.sv
module test_ctl_reg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, vblank = 1'b0;
  logic sda_oe, hloop;
  logic [151:0] regs;
  logic sda_bus;
  int checks = 0, fails = 0, pulses = 0, exp_pulses = 0;
  logic [7:0] m_stage [19];
  logic [7:0] m_act   [19];

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  ctl_reg_slave i_ctl_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .vblank_i(vblank), .sda_oe_o(sda_oe), .regs_o(regs), .hloop_start_o(hloop)
  );

  always @(negedge clk) if (rst_n && hloop) pulses++;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    int bad = -1;
    for (int k = 0; k < 19; k++) if (bad < 0 && regs[k*8 +: 8] != m_act[k]) bad = k;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s reg%0d actual=%0h expected=%0h", req, bad, regs[bad*8 +: 8], m_act[bad]);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(4); scl_m = 1'b1; hold(4); sda_m = 1'b0; hold(4); scl_m = 1'b0; hold(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(4); scl_m = 1'b1; hold(8); sda_m = 1'b1; hold(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hold(4); scl_m = 1'b1; hold(4);
      if (i == 0) chk("R11 no drive in data bit", int'(sda_oe), 0);
      hold(4); scl_m = 1'b0; hold(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; hold(4); scl_m = 1'b1; hold(4);
    acked = ~sda_bus;
    hold(4); scl_m = 1'b0; hold(4);
  endtask

  function automatic int sub_index(input logic [7:0] s);
    if (s == 8'h00) return 18;
    if (s >= 8'h77 && s <= 8'h88) return int'(s) - 'h77;
    return -1;
  endfunction

  task automatic settle();
    hold(12);
    if (vblank) for (int k = 0; k < 19; k++) m_act[k] = m_stage[k];
  endtask

  task automatic write3(input string req, input logic [7:0] a, input logic [7:0] s, input logic [7:0] d);
    logic a0, a1, a2;
    int idx;
    bit e0, e1;
    idx = sub_index(s);
    e0 = (a == 8'h8A);
    e1 = e0 && idx >= 0;
    bus_start();
    send_byte(a, a0); send_byte(s, a1); send_byte(d, a2);
    bus_stop();
    chk({req, " ack addr"}, int'(a0), int'(e0));
    chk({req, " ack sub"},  int'(a1), int'(e1));
    chk({req, " ack data"}, int'(a2), int'(e1));
    if (e1) begin
      if (idx == 18 && d == 8'h00 && !m_act[17][6]) exp_pulses++;
      m_stage[idx] = d;
    end
    settle();
    chk_regs({req, " regs"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    for (int k = 0; k < 19; k++) begin m_stage[k] = 8'h00; m_act[k] = 8'h00; end
    hold(3);
    chk("R9 reset regs", int'(regs == '0), 1);
    chk("R9 reset oe", int'(sda_oe), 0);
    chk("R9 reset pulse", int'(hloop), 0);
    rst_n = 1'b1; hold(4);

    vblank = 1'b1;
    write3("R2 R3 R6 basic", 8'h8A, 8'h77, 8'h3F);
    write3("R3 top sel", 8'h8A, 8'h88, 8'hA5);

    vblank = 1'b0;
    write3("R6 staged hidden", 8'h8A, 8'h7B, 8'h2A);
    vblank = 1'b1; settle();
    chk_regs("R6 released in blank");

    write3("R4 wrong addr", 8'h8C, 8'h79, 8'h55);
    write3("R5 bad sub", 8'h8A, 8'h90, 8'h66);
    write3("R5 bad sub low", 8'h8A, 8'h76, 8'h67);

    // R8 stop after two bytes, then bytes with no start
    bus_start(); send_byte(8'h8A, ack); send_byte(8'h7A, ack); bus_stop();
    send_byte(8'h8A, ack);
    chk("R8 no ack after stop", int'(ack), 0);
    bus_stop(); settle();
    chk_regs("R8 regs unchanged");

    // R10 restart mid-byte and mid-transaction
    bus_start(); send_byte(8'h8A, ack); send_byte(8'h78, ack); send_bits(8'hF0, 4);
    write3("R10 R1 restart mid-byte", 8'h8A, 8'h79, 8'h11);
    bus_start(); send_byte(8'h8A, ack);
    write3("R10 R1 restart after addr", 8'h8A, 8'h7C, 8'h22);

    // R7 horizontal loop strobe
    write3("R7 set gate", 8'h8A, 8'h88, 8'h40);
    write3("R7 gated strobe", 8'h8A, 8'h00, 8'h00);
    chk("R7 no pulse when gated", pulses, exp_pulses);
    write3("R7 clear gate", 8'h8A, 8'h88, 8'h00);
    write3("R7 strobe", 8'h8A, 8'h00, 8'h00);
    chk("R7 one pulse", pulses, exp_pulses);
    write3("R7 nonzero data", 8'h8A, 8'h00, 8'h05);
    chk("R7 no pulse nonzero", pulses, exp_pulses);

    // R3 sweep every selector
    for (int k = 0; k < 19; k++) begin
      logic [7:0] s = (k == 18) ? 8'h00 : 8'(8'h77 + k);
      write3("R3 sweep", 8'h8A, s, 8'((k * 13 + 5) | 1) & 8'hBF);
    end
    chk("R7 sweep pulses", pulses, exp_pulses);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule